// File: doc/BRIEF.md
# BCD Real-Time Calendar Counter

This block keeps wall-clock time and a calendar as packed BCD registers. A free-running 32.768 kHz clock enable drives a sub-second prescaler. Once per second the prescaler advances the seconds field. Carries then ripple through minutes, hours (24-hour), day of month, weekday, month and year, and a century bit toggles when the year wraps.

Host software reaches every register through a small synchronous port. The port supports single-byte reads and writes, and an auto-incrementing pointer lets seven time bytes move as one block.

To load a new time safely, software first sets a freeze bit in the first control register. While that bit is set, neither the prescaler nor the counters move. Software then writes the time bytes and clears the freeze bit. The next increment comes one full second later.

The top bit of the seconds byte is a sticky "time not trusted" flag. It is raised by reset and dropped only when software writes the seconds register.

Top module: `rtc_bcd_core`

## Requirements
- R1: After reset, reads return 0x00 at 0x00 and 0x01, 0x80 at 0x02 (invalid flag set, seconds 00), 0x00 at 0x03, 0x04 and 0x06, 0x01 at 0x05, 0x01 at 0x07 and 0x00 at 0x08.
- R2: Timing and the freeze bit:
  - The seconds field advances by one BCD step after every PRESCALE asserted `tick_en` cycles.
  - While bit 5 of address 0x00 is 1, further `tick_en` pulses change no time field.
- R3: When the freeze bit is cleared, the partial prescaler count is discarded. The next seconds increment needs a full PRESCALE `tick_en` pulses.
- R4: The invalid flag is bit 7 of the seconds byte. It is set by reset, and it is cleared by any host write to 0x02, whatever value bit 7 of the written data has. Nothing else sets or clears it.
- R5: Port timing and block access:
  - A read request (`req`=1, `we`=0) returns data on `rdata` with `rvalid` high exactly one cycle later.
  - With `seq`=1, the access uses the previous access address plus one.
  - A seven-byte access starting at 0x02 covers seconds, minutes, hours, day, weekday, month and year.
- R6: Writes are masked to the field widths: seconds and minutes 7 bits, hours and day 6 bits, weekday 3 bits, month 5 bits plus the century flag in bit 7. The year keeps all 8 bits.
- R7: Time rollovers:
  - Seconds 59 wraps to 00 and carries into minutes.
  - Minutes 59 wraps to 00 and carries into hours.
  - Hours 23 wraps to 00, carries a day, and the weekday goes 6 to 0.
- R8: Day rollover:
  - The day wraps to 01 and the month advances when the day reaches the month length.
  - The length is 30 for months 04, 06, 09 and 11, and 31 for the other months except February.
  - February has 29 days in years divisible by 4 and 28 otherwise.
- R9: Month 12 wraps to 01 and increments the year. Year 99 wraps to 00 and toggles the century flag (bit 7 of 0x07).
- R10: At 0x00, bits 7 and 3 store and read back as written, and bit 5 is the freeze bit. The other bits read 0. Address 0x01 stores and returns a full byte.
- R11: Addresses 0x09 to 0x0F read 0x00, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | 32.768 kHz clock-enable pulse |
| req | input | 1 | Access request |
| we | input | 1 | 1 = write, 0 = read |
| seq | input | 1 | 1 = use incremented pointer instead of `addr` |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid with `rvalid` |
| rvalid | output | 1 | Read data valid, one cycle after a read request |

## Verification
A wrong carry or length decision stays invisible until the affected boundary is crossed. After that it shows in a register read taken right after a single second step. The bench therefore loads times just before each boundary: minute, hour, day, each month-length class, leap and non-leap February, and year/century. It then reads the whole block back after exactly one prescaler period.

A prescaler that keeps its partial count across a freeze shows as a seconds value one step early. That difference is visible on the first read after fewer than PRESCALE pulses. A leaking invalid flag appears in bit 7 of the very next seconds read.

// File: rtl/rtc_bcd_pkg.sv
// Shared constants, calendar record type and BCD helper functions.
// Assumes all stored time fields hold valid packed BCD.
package rtc_bcd_pkg;

    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_CTL1  = 4'h0;
    localparam logic [ADDR_W-1:0] A_CTL2  = 4'h1;
    localparam logic [ADDR_W-1:0] A_SEC   = 4'h2;
    localparam logic [ADDR_W-1:0] A_MIN   = 4'h3;
    localparam logic [ADDR_W-1:0] A_HOUR  = 4'h4;
    localparam logic [ADDR_W-1:0] A_DAY   = 4'h5;
    localparam logic [ADDR_W-1:0] A_WDAY  = 4'h6;
    localparam logic [ADDR_W-1:0] A_MONTH = 4'h7;
    localparam logic [ADDR_W-1:0] A_YEAR  = 4'h8;

    typedef struct packed {
        logic [6:0] sec;
        logic [6:0] min;
        logic [5:0] hour;
        logic [5:0] day;
        logic [2:0] wday;
        logic       century;
        logic [4:0] month;
        logic [7:0] year;
    } cal_t;

    // Add one to a two-digit packed BCD value (99 gives A0; callers wrap).
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
        else                return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Leap test on a BCD year: (2*tens + units) mod 4 == 0.
    function automatic logic leap_year(input logic [7:0] y);
        logic [1:0] s;
        s = y[1:0] + {y[4], 1'b0};
        return (s == 2'b00);
    endfunction

    // Month length in BCD for a BCD month.
    function automatic logic [7:0] days_in_month(input logic [4:0] m, input logic leap);
        case (m)
            5'h02:                      return leap ? 8'h29 : 8'h28;
            5'h04, 5'h06, 5'h09, 5'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
// Sub-second divider: emits one-cycle sec_pulse every PRESCALE tick_en pulses.
// Assumes PRESCALE >= 2. While hold is high the count is cleared and frozen,
// so counting restarts from zero when hold drops.
module rtc_prescaler #(
    parameter int PRESCALE = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic hold,
    output logic sec_pulse
);
    localparam int CNT_W = $clog2(PRESCALE);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PRESCALE - 1);

    logic [CNT_W-1:0] cnt_q;

    assign sec_pulse = tick_en && !hold && (cnt_q == LAST);

    // Count enable pulses, wrap at LAST, clear while held.
    always_ff @(posedge clk) begin
        if (!rst_n || hold)  cnt_q <= '0;
        else if (sec_pulse)  cnt_q <= '0;
        else if (tick_en)    cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/rtc_calendar.sv
// Time and calendar counters in packed BCD with a carry chain from seconds
// to century. A host write to a field overrides that field's carry result
// in the same cycle. Assumes stored fields hold valid BCD.
module rtc_calendar
    import rtc_bcd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output cal_t              cal
);
    cal_t       cal_q, cal_d;
    logic [7:0] mlen;
    logic       c_min, c_hour, c_day, c_mon, c_year;

    assign mlen   = days_in_month(cal_q.month, leap_year(cal_q.year));
    assign c_min  = step   && (cal_q.sec  == 7'h59);
    assign c_hour = c_min  && (cal_q.min  == 7'h59);
    assign c_day  = c_hour && (cal_q.hour == 6'h23);
    assign c_mon  = c_day  && ({2'b00, cal_q.day} >= mlen);
    assign c_year = c_mon  && (cal_q.month == 5'h12);

    // Next state: carry ripple first, then host write override.
    always_comb begin
        cal_d = cal_q;
        if (step)
            cal_d.sec = c_min ? 7'h00 : 7'(bcd_inc({1'b0, cal_q.sec}));
        if (c_min)
            cal_d.min = c_hour ? 7'h00 : 7'(bcd_inc({1'b0, cal_q.min}));
        if (c_hour)
            cal_d.hour = c_day ? 6'h00 : 6'(bcd_inc({2'b00, cal_q.hour}));
        if (c_day) begin
            cal_d.wday = (cal_q.wday >= 3'd6) ? 3'd0 : cal_q.wday + 3'd1;
            cal_d.day  = c_mon ? 6'h01 : 6'(bcd_inc({2'b00, cal_q.day}));
        end
        if (c_mon)
            cal_d.month = c_year ? 5'h01 : 5'(bcd_inc({3'b000, cal_q.month}));
        if (c_year) begin
            if (cal_q.year == 8'h99) begin
                cal_d.year    = 8'h00;
                cal_d.century = ~cal_q.century;
            end else begin
                cal_d.year = bcd_inc(cal_q.year);
            end
        end
        if (wr_en) begin
            case (wr_addr)
                A_SEC:   cal_d.sec  = wr_data[6:0];
                A_MIN:   cal_d.min  = wr_data[6:0];
                A_HOUR:  cal_d.hour = wr_data[5:0];
                A_DAY:   cal_d.day  = wr_data[5:0];
                A_WDAY:  cal_d.wday = wr_data[2:0];
                A_MONTH: begin
                    cal_d.month   = wr_data[4:0];
                    cal_d.century = wr_data[7];
                end
                A_YEAR:  cal_d.year = wr_data;
                default: ;
            endcase
        end
    end

    // State register with calendar reset value 00:00:00, day 01, month 01.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cal_q       <= '0;
            cal_q.day   <= 6'h01;
            cal_q.month <= 5'h01;
        end else begin
            cal_q <= cal_d;
        end
    end

    assign cal = cal_q;
endmodule

// File: rtl/rtc_bcd_core.sv
// Top: register port, control registers, invalid flag and read mux around
// the prescaler and calendar. Reads are registered (one cycle latency).
// seq=1 addresses the register after the previous access.
module rtc_bcd_core
    import rtc_bcd_pkg::*;
#(
    parameter int PRESCALE = 32768
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              req,
    input  logic              we,
    input  logic              seq,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              rvalid
);
    logic [ADDR_W-1:0] ptr_q, cur_addr;
    logic [2:0]        ctl1_q;   // {test7, freeze, test3}
    logic [7:0]        ctl2_q;
    logic              inval_q, wr, stop, sec_pulse;
    logic [7:0]        rd_mux;
    cal_t              cal_q;

    assign cur_addr = seq ? ptr_q : addr;
    assign wr       = req && we;
    assign stop     = ctl1_q[1];

    rtc_prescaler #(.PRESCALE(PRESCALE)) u_presc (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .hold(stop), .sec_pulse(sec_pulse)
    );

    rtc_calendar u_cal (
        .clk(clk), .rst_n(rst_n), .step(sec_pulse),
        .wr_en(wr), .wr_addr(cur_addr), .wr_data(wdata), .cal(cal_q)
    );

    // Address pointer follows every access for sequential mode.
    always_ff @(posedge clk) begin
        if (!rst_n)   ptr_q <= '0;
        else if (req) ptr_q <= cur_addr + 1'b1;
    end

    // Control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl1_q <= '0;
            ctl2_q <= '0;
        end else if (wr && cur_addr == A_CTL1) begin
            ctl1_q <= {wdata[7], wdata[5], wdata[3]};
        end else if (wr && cur_addr == A_CTL2) begin
            ctl2_q <= wdata;
        end
    end

    // Sticky invalid flag: set by reset, cleared by a seconds write.
    always_ff @(posedge clk) begin
        if (!rst_n)                    inval_q <= 1'b1;
        else if (wr && cur_addr == A_SEC) inval_q <= 1'b0;
    end

    // Read data selection.
    always_comb begin
        case (cur_addr)
            A_CTL1:  rd_mux = {ctl1_q[2], 1'b0, ctl1_q[1], 1'b0, ctl1_q[0], 3'b000};
            A_CTL2:  rd_mux = ctl2_q;
            A_SEC:   rd_mux = {inval_q, cal_q.sec};
            A_MIN:   rd_mux = {1'b0, cal_q.min};
            A_HOUR:  rd_mux = {2'b00, cal_q.hour};
            A_DAY:   rd_mux = {2'b00, cal_q.day};
            A_WDAY:  rd_mux = {5'b00000, cal_q.wday};
            A_MONTH: rd_mux = {cal_q.century, 2'b00, cal_q.month};
            A_YEAR:  rd_mux = cal_q.year;
            default: rd_mux = 8'h00;
        endcase
    end

    // Registered read response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= req && !we;
            if (req && !we) rdata <= rd_mux;
        end
    end
endmodule

// File: rtl/rtc_bcd_core_chk.sv
// Property checker for rtc_bcd_core, attached by bind.
module rtc_bcd_core_chk
    import rtc_bcd_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req,
    input logic              we,
    input logic [ADDR_W-1:0] cur_addr,
    input logic              stop,
    input logic              inval,
    input logic [6:0]        sec,
    input logic              rvalid
);
    logic sec_wr;
    assign sec_wr = req && we && (cur_addr == A_SEC);

    // R4: once cleared, the invalid flag never comes back outside reset.
    a_r4_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !inval |=> !inval);

    // R4: a seconds write always clears the flag.
    a_r4_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        sec_wr |=> !inval);

    // R2: frozen seconds stay put unless written.
    a_r2_freeze_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !sec_wr) |=> $stable(sec));

    // R5: every read request answers one cycle later.
    a_r5_read_answer: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !we) |=> rvalid);

    // R5: no response without a read request.
    a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !(req && !we) |=> !rvalid);
endmodule

bind rtc_bcd_core rtc_bcd_core_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .cur_addr(cur_addr),
    .stop(stop), .inval(inval_q), .sec(cal_q.sec), .rvalid(rvalid)
);

// File: tb/rtc_bcd_core_bench.sv
module rtc_bcd_core_bench;
    localparam int CLK_P = 10;
    localparam int PS    = 4;

    logic       clk = 0, rst_n = 0, tick_en = 0, req = 0, we = 0, seq = 0;
    logic [3:0] addr = 0;
    logic [7:0] wdata = 0;
    logic [7:0] rdata;
    logic       rvalid;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #(CLK_P/2) clk = ~clk;

    rtc_bcd_core #(.PRESCALE(PS)) u_rtc_bcd_core (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .req(req), .we(we),
        .seq(seq), .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid)
    );

    // Monitor: pop and compare each read response.
    always @(negedge clk) begin
        if (rst_n && rvalid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R5 unexpected read data: actual %02h expected none", rdata);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rdata !== e) begin
                    errors++;
                    $display("FAIL %s: actual %02h expected %02h", t, rdata, e);
                end
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        req = 1; we = 1; seq = 0; addr = a; wdata = d;
        @(posedge clk); #1;
        req = 0; we = 0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [7:0] e, input string t);
        @(posedge clk); #1;
        req = 1; we = 0; seq = 0; addr = a;
        exp_q.push_back(e); tag_q.push_back(t);
        @(posedge clk); #1;
        req = 0;
    endtask

    task automatic blk_wr(input logic [7:0] b [7]);
        @(posedge clk); #1;
        for (int i = 0; i < 7; i++) begin
            req = 1; we = 1; seq = (i != 0); addr = 4'h2; wdata = b[i];
            @(posedge clk); #1;
        end
        req = 0; we = 0; seq = 0;
    endtask

    task automatic blk_rd(input logic [7:0] b [7], input string t);
        @(posedge clk); #1;
        for (int i = 0; i < 7; i++) begin
            req = 1; we = 0; seq = (i != 0); addr = 4'h2;
            exp_q.push_back(b[i]); tag_q.push_back(t);
            @(posedge clk); #1;
        end
        req = 0; seq = 0;
    endtask

    task automatic ticks(input int n);
        @(posedge clk); #1;
        tick_en = 1;
        repeat (n) @(posedge clk);
        #1 tick_en = 0;
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1 reset state
        rd(4'h0, 8'h00, "R1 ctl1"); rd(4'h1, 8'h00, "R1 ctl2");
        rd(4'h2, 8'h80, "R1 sec"); rd(4'h3, 8'h00, "R1 min");
        rd(4'h4, 8'h00, "R1 hour"); rd(4'h5, 8'h01, "R1 day");
        rd(4'h6, 8'h00, "R1 wday"); rd(4'h7, 8'h01, "R1 month");
        rd(4'h8, 8'h00, "R1 year");
        // R4 seconds write clears flag even with bit 7 written
        wr(4'h2, 8'h85); rd(4'h2, 8'h05, "R4 flag cleared");
        // R2 one second per PS pulses, partial count no change
        ticks(PS); rd(4'h2, 8'h06, "R2 one second");
        ticks(PS - 1); rd(4'h2, 8'h06, "R2 partial");
        wr(4'h0, 8'h20); ticks(3 * PS); rd(4'h2, 8'h06, "R2 frozen");
        rd(4'h0, 8'h20, "R10 freeze bit");
        // R3 restart needs full period
        wr(4'h0, 8'h00); ticks(PS - 1); rd(4'h2, 8'h06, "R3 partial after restart");
        ticks(1); rd(4'h2, 8'h07, "R3 full period");
        // R10 control bits
        wr(4'h0, 8'hFF); rd(4'h0, 8'hA8, "R10 ctl1 mask");
        wr(4'h0, 8'h88); rd(4'h0, 8'h88, "R10 test bits");
        ticks(PS); rd(4'h2, 8'h08, "R10 test bits no effect");
        wr(4'h0, 8'h00);
        wr(4'h1, 8'h5A); rd(4'h1, 8'h5A, "R10 ctl2");
        // R11 unmapped
        wr(4'hA, 8'hFF); rd(4'hA, 8'h00, "R11 write ignored");
        rd(4'h9, 8'h00, "R11 addr 9"); rd(4'hF, 8'h00, "R11 addr F");
        rd(4'h2, 8'h08, "R11 no side effect");
        // R6 masks
        wr(4'h2, 8'hFF); rd(4'h2, 8'h7F, "R6 sec mask");
        wr(4'h3, 8'hFF); rd(4'h3, 8'h7F, "R6 min mask");
        wr(4'h4, 8'hFF); rd(4'h4, 8'h3F, "R6 hour mask");
        wr(4'h5, 8'hFF); rd(4'h5, 8'h3F, "R6 day mask");
        wr(4'h6, 8'hFF); rd(4'h6, 8'h07, "R6 wday mask");
        wr(4'h7, 8'hFF); rd(4'h7, 8'h9F, "R6 month mask");
        wr(4'h8, 8'hFF); rd(4'h8, 8'hFF, "R6 year full");
        // R5 block write/read, R7 minute-only carry
        blk_wr('{8'h59, 8'h10, 8'h08, 8'h15, 8'h02, 8'h06, 8'h23});
        blk_rd('{8'h59, 8'h10, 8'h08, 8'h15, 8'h02, 8'h06, 8'h23}, "R5 block");
        ticks(PS);
        blk_rd('{8'h00, 8'h11, 8'h08, 8'h15, 8'h02, 8'h06, 8'h23}, "R7 minute carry");
        // R7/R8 end of day, non-leap Feb
        blk_wr('{8'h59, 8'h59, 8'h23, 8'h28, 8'h06, 8'h02, 8'h23});
        ticks(PS);
        blk_rd('{8'h00, 8'h00, 8'h00, 8'h01, 8'h00, 8'h03, 8'h23}, "R8 Feb non-leap");
        // R8 leap Feb
        blk_wr('{8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h02, 8'h24});
        ticks(PS);
        blk_rd('{8'h00, 8'h00, 8'h00, 8'h29, 8'h03, 8'h02, 8'h24}, "R8 Feb leap 28");
        blk_wr('{8'h59, 8'h59, 8'h23, 8'h29, 8'h02, 8'h02, 8'h24});
        ticks(PS);
        blk_rd('{8'h00, 8'h00, 8'h00, 8'h01, 8'h03, 8'h03, 8'h24}, "R8 Feb leap 29");
        // R8 30-day month
        blk_wr('{8'h59, 8'h59, 8'h23, 8'h30, 8'h04, 8'h04, 8'h25});
        ticks(PS);
        blk_rd('{8'h00, 8'h00, 8'h00, 8'h01, 8'h05, 8'h05, 8'h25}, "R8 30-day");
        // R8 31-day month does not wrap at 30
        blk_wr('{8'h59, 8'h59, 8'h23, 8'h30, 8'h01, 8'h07, 8'h25});
        ticks(PS);
        blk_rd('{8'h00, 8'h00, 8'h00, 8'h31, 8'h02, 8'h07, 8'h25}, "R8 31-day");
        // R9 year and century wrap both directions
        blk_wr('{8'h59, 8'h59, 8'h23, 8'h31, 8'h01, 8'h12, 8'h99});
        ticks(PS);
        blk_rd('{8'h00, 8'h00, 8'h00, 8'h01, 8'h02, 8'h81, 8'h00}, "R9 century set");
        blk_wr('{8'h59, 8'h59, 8'h23, 8'h31, 8'h01, 8'h92, 8'h99});
        ticks(PS);
        blk_rd('{8'h00, 8'h00, 8'h00, 8'h01, 8'h02, 8'h01, 8'h00}, "R9 century clear");
        blk_wr('{8'h59, 8'h59, 8'h23, 8'h31, 8'h03, 8'h12, 8'h19});
        ticks(PS);
        blk_rd('{8'h00, 8'h00, 8'h00, 8'h01, 8'h04, 8'h01, 8'h20}, "R9 year BCD");
        // R4 flag stays clear
        rd(4'h2, 8'h00, "R4 flag sticky");
        repeat (4) @(posedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R5 missing responses: actual %0d pending expected 0", exp_q.size());
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule